// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 256 words of 9 bits. Words enter on a write clock and leave on a read clock. The two clocks may be one net or two unrelated sources. A word is stored only when a low-active write enable and a high-active qualifier are both asserted. A word is removed only when two low-active read enables are asserted together. The read word sits in a register, and an output enable places the 9-bit bus in high impedance.

Four active-low status flags report the fill level. Empty and almost-empty belong to the read clock domain. Full and almost-full belong to the write clock domain. Each almost flag compares the level against an offset input. A separate loader block owns these offsets and presets both of them to 7.

Each pointer crosses to the other domain as Gray code through two flip-flops. The crossed pointer lags the true one, so a flag can clear a few cycles late, but it never asserts late. Reset is synchronous and active high. It must be held for at least three edges of each clock.

Top module: `dcf_fifo`

## Requirements
- R1: While `rst` is high, both pointers return to zero and the stored read word becomes 0. After reset, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1.
- R2: A word is written on a rising `wr_clk` edge only when, at that edge, `wr_en_n`=0, `wr_en2`=1 and `full_n`=1. Every other combination leaves the contents unchanged.
- R3: A word is read on a rising `rd_clk` edge only when, at that edge, `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1.
- R4: Words leave in the order they were accepted. A word is visible on `rd_data` after the `rd_clk` edge that accepted its read.
- R5: `empty_n` is 0 whenever no unread word is held. Once traffic stops and three `rd_clk` edges have passed, `empty_n` is 1 exactly when at least one unread word is held.
- R6: `full_n` is 0 whenever 256 words are held. Once traffic stops and three `wr_clk` edges have passed, `full_n` is 0 exactly when 256 words are held.
- R7: With traffic stopped, `aempty_n` is 0 exactly when the fill level is less than or equal to `ae_offset`.
- R8: With traffic stopped, `afull_n` is 0 exactly when the free space (256 minus the fill level) is less than or equal to `af_offset`.
- R9: When `oe_n`=1, every bit of `rd_data` is high impedance. When `oe_n`=0, the stored read word is driven.
- R10: The stored read word changes only on an accepted read. It keeps its value while reads are disabled or the FIFO is empty.
- R11: Behaviour R2 to R10 holds unchanged when `rd_clk` and `wr_clk` are the same signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Write qualifier, active high |
| wr_data | input | 9 | Word to store |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable for `rd_data`, active low |
| ae_offset | input | 8 | Almost-empty threshold, from the loader block |
| af_offset | input | 8 | Almost-full threshold, from the loader block |
| rd_data | output | 9 | Stored read word, or high impedance |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when almost full (write domain) |

## Verification
The bench builds the block with its default parameters: 9-bit data and 256 words. At this size the FIFO fills completely, so writes attempted against a full buffer can be seen to be dropped. Thousands of words are streamed, which wraps both 9-bit pointers several times. The flag thresholds are reached from both sides, with the almost-empty offset at 7 and at 8.

Streaming runs first with a 10 ns write clock against a 13 ns read clock. It then runs again with the two clocks tied together. This covers the Gray-code crossing under both unrelated and identical clock phases.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int GRAY_MAX_W = 32;

    typedef logic [GRAY_MAX_W-1:0] gvec_t;

    // hard_n: empty or full; soft_n: almost-empty or almost-full
    typedef struct packed {
        logic hard_n;
        logic soft_n;
    } flag_pair_t;

    function automatic gvec_t bin_to_gray(gvec_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic gvec_t gray_to_bin(gvec_t g);
        gvec_t b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] af_offset,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          fire,
    output flag_pair_t    flags
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rbin_s, fill, free_sp, wnext;

    assign rbin_s  = PW'(gray_to_bin(GRAY_MAX_W'(rgray_s)));
    assign fill    = wptr - rbin_s;
    assign free_sp = PW'(DEPTH) - fill;

    assign flags.hard_n = (fill != PW'(DEPTH));
    assign flags.soft_n = !(free_sp <= {1'b0, af_offset});

    assign fire  = req & flags.hard_n;
    assign wnext = wptr + PW'(fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wnext;
            wgray <= PW'(bin_to_gray(GRAY_MAX_W'(wnext)));
        end
    end

    // R2: the write pointer only ever holds or steps by one
    p_wptr_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wptr == $past(wptr) || wptr == $past(wptr) + 1'b1));

    // R11: the crossing word changes at most one bit per edge
    p_wgray_onebit_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

    // R6: the write-side view never exceeds capacity
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        fill <= PW'(DEPTH));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_offset,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic          fire,
    output flag_pair_t    flags
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin_s, fill, rnext;

    assign wbin_s = PW'(gray_to_bin(GRAY_MAX_W'(wgray_s)));
    assign fill   = wbin_s - rptr;

    assign flags.hard_n = (fill != '0);
    assign flags.soft_n = !(fill <= {1'b0, ae_offset});

    assign fire  = req & flags.hard_n;
    assign rnext = rptr + PW'(fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            rgray <= '0;
        end else begin
            rptr  <= rnext;
            rgray <= PW'(bin_to_gray(GRAY_MAX_W'(rnext)));
        end
    end

    // R3: an empty view leaves the read pointer in place on the next edge
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        !flags.hard_n |=> (rptr == $past(rptr)));

    // R11: the crossing word changes at most one bit per edge
    p_rgray_onebit_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

    // R5: the read-side view never exceeds capacity
    p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
        fill <= PW'(DEPTH));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 256
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic              wr_en2,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    input  logic [$clog2(DEPTH)-1:0] ae_offset,
    input  logic [$clog2(DEPTH)-1:0] af_offset,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              full_n,
    output logic              afull_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic [PW-1:0] wptr, wgray, rptr, rgray, wgray_rs, rgray_ws;
    logic wr_fire, rd_fire;
    flag_pair_t wflags, rflags;

    dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_rs));
    dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_ws));

    dcf_wr_side #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(rst), .req(!wr_en_n && wr_en2),
        .rgray_s(rgray_ws), .af_offset(af_offset),
        .wptr(wptr), .wgray(wgray), .fire(wr_fire), .flags(wflags));

    dcf_rd_side #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst(rst), .req(!rd_en1_n && !rd_en2_n),
        .wgray_s(wgray_rs), .ae_offset(ae_offset),
        .rptr(rptr), .rgray(rgray), .fire(rd_fire), .flags(rflags));

    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[wptr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
        if (rst)          rd_q <= '0;
        else if (rd_fire) rd_q <= mem[rptr[AW-1:0]];
    end

    assign rd_data  = oe_n ? 'z : rd_q;
    assign empty_n  = rflags.hard_n;
    assign aempty_n = rflags.soft_n;
    assign full_n   = wflags.hard_n;
    assign afull_n  = wflags.soft_n;

    // R10: the stored read word holds across any edge without an accepted read
    p_hold_r10: assert property (@(posedge rd_clk) disable iff (rst)
        !rd_fire |=> $stable(rd_q));
endmodule

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/100ps
module tb_dcf_fifo;
    localparam int DW = 9;
    localparam int DEPTH = 256;

    logic wr_clk = 0, rclk_free = 0, tie = 0, rst = 1;
    logic rd_clk;
    logic wr_en_n = 1, wr_en2 = 0, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
    logic [DW-1:0] wr_data = '0;
    logic [7:0] ae_offset = 8'd7, af_offset = 8'd7;
    logic [DW-1:0] rd_data;
    logic empty_n, aempty_n, full_n, afull_n;

    int compared = 0, mismatched = 0;
    int w_mode = 0, r_mode = 0;
    bit done = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] exp_q = '0;

    always #5 wr_clk = ~wr_clk;
    always #6.5 rclk_free = ~rclk_free;
    assign rd_clk = tie ? wr_clk : rclk_free;

    dcf_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en_n(wr_en_n), .wr_en2(wr_en2), .wr_data(wr_data),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
        .ae_offset(ae_offset), .af_offset(af_offset),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n),
        .full_n(full_n), .afull_n(afull_n));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // write side model and driver; modes: 0 idle, 1 write, 2 random,
    // 3 en_n=0/en2=0, 4 en_n=1/en2=1, 5 en_n=1/en2=0
    always @(negedge wr_clk) begin
        if (!rst) begin
            bit n, e2;
            if (q.size() == DEPTH) chk(full_n == 1'b0, "R6", full_n, 0);
            case (w_mode)
                1: begin n = 0; e2 = 1; end
                2: begin n = ($urandom & 1) != 0; e2 = 1; end
                3: begin n = 0; e2 = 0; end
                4: begin n = 1; e2 = 1; end
                5: begin n = 1; e2 = 0; end
                default: begin n = 1; e2 = 0; end
            endcase
            wr_en_n = n;
            wr_en2  = e2;
            wr_data = DW'($urandom);
            if (!n && e2 && full_n) q.push_back(wr_data);  // R2
        end
    end

    // read side model and driver; modes: 0 idle, 1 read, 2 random, 3 en1 only, 4 en2 only
    always @(negedge rd_clk) begin
        if (!rst) begin
            bit a, b;
            if (!oe_n) chk(rd_data === exp_q, "R4", int'(rd_data), int'(exp_q)); // also R10 hold
            if (q.size() == 0) chk(empty_n == 1'b0, "R5", empty_n, 0);
            case (r_mode)
                1: begin a = 0; b = 0; end
                2: begin a = ($urandom & 1) != 0; b = 0; end
                3: begin a = 0; b = 1; end
                4: begin a = 1; b = 0; end
                default: begin a = 1; b = 1; end
            endcase
            rd_en1_n = a;
            rd_en2_n = b;
            if (!a && !b && empty_n) begin  // R3
                if (q.size() == 0) chk(1'b0, "R5", 1, 0);
                else exp_q = q.pop_front();
            end
        end
    end

    task automatic wr_burst(input int n, input int mode = 1);
        @(posedge wr_clk); w_mode = mode;
        repeat (n) @(posedge wr_clk);
        w_mode = 0;
    endtask

    task automatic rd_burst(input int n, input int mode = 1);
        @(posedge rd_clk); r_mode = mode;
        repeat (n) @(posedge rd_clk);
        r_mode = 0;
    endtask

    task automatic settle_check();
        int lvl;
        repeat (12) @(negedge wr_clk);
        #1;
        lvl = q.size();
        chk(empty_n  == (lvl != 0), "R5", empty_n, lvl != 0);
        chk(full_n   == (lvl != DEPTH), "R6", full_n, lvl != DEPTH);
        chk(aempty_n == !(lvl <= int'(ae_offset)), "R7", aempty_n, !(lvl <= int'(ae_offset)));
        chk(afull_n  == !((DEPTH - lvl) <= int'(af_offset)), "R8", afull_n,
            !((DEPTH - lvl) <= int'(af_offset)));
    endtask

    initial begin
        #1_500_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (8) @(posedge wr_clk);
        @(negedge wr_clk); rst = 0;
        #1;
        // R1 reset state
        chk(empty_n == 0, "R1", empty_n, 0);
        chk(aempty_n == 0, "R1", aempty_n, 0);
        chk(full_n == 1, "R1", full_n, 1);
        chk(afull_n == 1, "R1", afull_n, 1);
        chk(rd_data === 9'd0, "R1", int'(rd_data), 0);

        wr_burst(5);  settle_check();   // R7 below threshold
        wr_burst(3);  settle_check();   // level 8 above 7
        ae_offset = 8'd8; settle_check(); // R7 boundary at equality
        wr_burst(10, 3); wr_burst(10, 4); wr_burst(10, 5);
        settle_check();                 // R2: level must still be 8
        chk(q.size() == 8, "R2", q.size(), 8);
        ae_offset = 8'd7;

        wr_burst(260); settle_check();  // R6 full, writes beyond dropped
        rd_burst(7);   settle_check();  // R8 free 7
        rd_burst(1);   settle_check();  // R8 free 8
        rd_burst(10, 3); rd_burst(10, 4);
        settle_check();                 // R3 partial enables ignored
        chk(q.size() == 248, "R3", q.size(), 248);

        @(negedge rd_clk); oe_n = 1; #1;
        chk(rd_data === 9'bz_zzzz_zzzz, "R9", int'(rd_data), 0);
        oe_n = 0; #1;
        chk(!$isunknown(rd_data), "R9", int'(rd_data), int'(exp_q));

        rd_burst(300); settle_check();  // drain, over-reads leave R10 hold

        fork wr_burst(4000, 2); rd_burst(3000, 2); join
        rd_burst(300); settle_check();

        tie = 1;                        // R11 tied clocks
        repeat (5) @(posedge wr_clk);
        fork wr_burst(3000, 2); rd_burst(3000, 2); join
        wr_burst(300); settle_check();
        rd_burst(300); settle_check();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule